// File: doc/BRIEF.md
# PLL Divider Coefficient Search Engine

This block finds a set of PLL dividers for a requested output clock. A start pulse brings in a reference frequency and a target frequency, both in Hz. The engine then steps through every combination of post-divider shift, pre-divider R and feedback multiplier F. It keeps the candidate that scores best while holding the VCO inside its legal band, and it only accepts candidates whose output clock falls inside a narrow window around the target. When the search ends it pulses `done` and presents R, F, an encoded post-divider code, the clock that was achieved and a found flag.

All quotients come from one shared iterative 32-bit unsigned divider, and all arithmetic is 32-bit unsigned with truncating division. The search order and the tie-break matter, because two different settings often land inside the window. For that reason the order is fixed:

- The post-divider shift is visited in the order 1, 2, 0.
- Inside each shift, R rises from 2 to 33.
- Inside each R, F rises from an estimate that is computed once per R.

Top module: `pll_coef_search`

## Requirements
- R1: A `start` seen while idle raises `busy` on the next cycle. On completion `done` is high for exactly one cycle with `busy` low. The result outputs change only in a cycle where `done` is high.
- R2: The search visits the shift OD in the order 1, 2, 0. For each OD it visits R = 2 to 33 in rising order. For each R it visits F in rising order while 2 ≤ F ≤ 513.
- R3: A candidate is acceptable only if its output clock (VCO >> OD) lies between target − (target >> 8) and target + (target >> 8), both limits included.
- R4: The candidate VCO is F × (ref / R), with integer division. It must lie between 100 000 000 and 500 000 000 Hz, both limits included.
- R5: The first F tried for each R is E = R × ((target >> 8) << OD) / (ref >> 8), lowered by one when E > 2. The score is ((ref/R − ref/33) / ((ref − ref/33) >> 10)) + ((VCO − 100 000 000) / 390 625).
- R6: While the stored score is zero, any acceptable candidate is stored. After that, a later candidate replaces the stored one only if its score is ≥ the stored score and its OD is nonzero. `found` is high when the final stored score is nonzero.
- R7: The 2-bit `p_code` output reports OD 0 as 0, OD 1 as 1 and OD 2 as 3. The value 2 is never reported.
- R8: When nothing was found, `found`, `r_val`, `f_val`, `p_code` and `clk_hz` are all zero at `done`.
- R9: A `start` pulse seen while `busy` is high is ignored. The running search finishes with the operands it latched.
- R10: When `found` is high, `r_val` is in 2..33 and `f_val` is in 2..513.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a search when the block is idle |
| ref_hz | input | 32 | Reference frequency in Hz, latched at start |
| target_hz | input | 32 | Wanted output frequency in Hz, latched at start |
| busy | output | 1 | High while a search runs |
| done | output | 1 | One-cycle pulse when results are ready |
| found | output | 1 | A candidate with nonzero score was kept |
| r_val | output | 6 | Chosen pre-divider R |
| f_val | output | 10 | Chosen feedback multiplier F |
| p_code | output | 2 | Encoded post-divider shift |
| clk_hz | output | 32 | Output clock of the chosen setting |

## Verification
The assertions assume that the products F × (ref / R) and R × ((target >> 8) << OD) never wrap in 32 bits. This holds while the reference stays between 1 MHz and 16 MHz and the target stays at or below 600 MHz. Within that range the phase denominator is also never zero. They also assume that `start` is raised only while the block is idle, or else is meant to be ignored. The stimulus keeps every reference and target inside these bounds. It covers targets that pick each of the three shifts, targets with no legal setting below and above the VCO band, and one deliberate `start` issued mid-search.

// File: rtl/pllsrch_pkg.sv
package pllsrch_pkg;

    localparam int unsigned DW        = 32;
    localparam int unsigned R_LO      = 2;
    localparam int unsigned R_HI      = 33;
    localparam int unsigned RW        = $clog2(R_HI + 1);
    localparam int unsigned F_LO      = 2;
    localparam int unsigned F_HI      = 513;
    localparam int unsigned FW        = $clog2(F_HI + 1);
    localparam int unsigned ODW       = 2;
    localparam int unsigned OD_STEPS  = 3;
    localparam int unsigned IDXW      = $clog2(OD_STEPS);
    localparam int unsigned WIN_SH    = 8;
    localparam int unsigned EST_SH    = 8;
    localparam int unsigned SCORE_SH  = 10;
    localparam int unsigned VCO_LO    = 100_000_000;
    localparam int unsigned VCO_HI    = 500_000_000;
    localparam int unsigned VCO_DEN   = (VCO_HI - VCO_LO) >> SCORE_SH;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_D33,
        ST_DREF,
        ST_DEST,
        ST_FCHK,
        ST_DPHS,
        ST_DVCO,
        ST_NEXTR,
        ST_DONE
    } srch_state_e;

    typedef struct packed {
        logic [RW-1:0]  r;
        logic [FW-1:0]  f;
        logic [ODW-1:0] od;
        logic [DW-1:0]  clk_hz;
        logic [DW-1:0]  score;
    } cand_t;

    // visiting order of the post-divider shift
    function automatic logic [ODW-1:0] od_of_idx(input logic [IDXW-1:0] idx);
        case (idx)
            IDXW'(0): od_of_idx = ODW'(1);
            IDXW'(1): od_of_idx = ODW'(2);
            default:  od_of_idx = ODW'(0);
        endcase
    endfunction

    // shifts of two or more report as code 3
    function automatic logic [ODW-1:0] p_of_od(input logic [ODW-1:0] od);
        p_of_od = (od >= ODW'(2)) ? ODW'(3) : od;
    endfunction

endpackage

// File: rtl/pllsrch_div.sv
module pllsrch_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         go,
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic         done,
    output logic [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [CW-1:0] cnt;
    logic          run;
    logic [W-1:0]  q;
    logic [W-1:0]  d;
    logic [W-1:0]  rem;
    logic [W-1:0]  n_keep;
    logic [W:0]    rem_sh;
    logic [W:0]    rem_sub;
    logic          take;

    always_comb begin
        rem_sh  = {rem, q[W-1]};
        take    = (rem_sh >= {1'b0, d});
        rem_sub = rem_sh - {1'b0, d};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            run    <= 1'b0;
            q      <= '0;
            d      <= '0;
            rem    <= '0;
            n_keep <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go) begin
                run    <= 1'b1;
                cnt    <= CW'(W);
                q      <= num;
                d      <= den;
                n_keep <= num;
                rem    <= '0;
            end else if (run) begin
                rem <= take ? rem_sub[W-1:0] : rem_sh[W-1:0];
                q   <= {q[W-2:0], take};
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    run  <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quo = q;

    // quotient and remainder rebuild the dividend (scores and estimates, R5)
    p_div_exact_r5: assert property (@(posedge clk) disable iff (rst)
        (done && d != '0) |->
        (({{W{1'b0}}, q} * {{W{1'b0}}, d}) + {{W{1'b0}}, rem}) == {{W{1'b0}}, n_keep});

    p_div_done_pulse_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: rtl/pllsrch_eval.sv
module pllsrch_eval
    import pllsrch_pkg::*;
(
    input  logic [FW-1:0]  f,
    input  logic [DW-1:0]  ref_per_r,
    input  logic [ODW-1:0] od,
    input  logic [DW-1:0]  win_lo,
    input  logic [DW-1:0]  win_hi,
    output logic [DW-1:0]  vco,
    output logic [DW-1:0]  out_clk,
    output logic           ok,
    output logic           beyond
);
    logic in_band;
    logic in_win;

    always_comb begin
        vco     = DW'({{(DW-FW){1'b0}}, f} * ref_per_r);
        out_clk = vco >> od;
        in_band = (vco >= VCO_LO) && (vco <= VCO_HI);
        in_win  = (out_clk >= win_lo) && (out_clk <= win_hi);
        ok      = in_band && in_win;
        beyond  = (vco > VCO_HI) || (out_clk > win_hi);
    end

endmodule

// File: rtl/pllsrch_best.sv
module pllsrch_best
    import pllsrch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clear,
    input  logic  offer,
    input  cand_t cand,
    output cand_t best,
    output logic  found
);
    logic take;

    always_comb begin
        found = (best.score != '0);
        take  = offer && (!found || ((cand.score >= best.score) && (cand.od != '0)));
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            best <= '0;
        end else if (take) begin
            best <= cand;
        end
    end

    p_score_no_drop_r6: assert property (@(posedge clk) disable iff (rst || clear)
        (offer && found) |=> (best.score >= $past(best.score)));

    p_zero_od_blocked_r6: assert property (@(posedge clk) disable iff (rst || clear)
        (offer && found && cand.od == '0) |=> $stable(best));

    p_first_taken_r6: assert property (@(posedge clk) disable iff (rst || clear)
        (offer && !found) |=> (best == $past(cand)));

endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
    import pllsrch_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [31:0]   ref_hz,
    input  logic [31:0]   target_hz,
    output logic          busy,
    output logic          done,
    output logic          found,
    output logic [5:0]    r_val,
    output logic [9:0]    f_val,
    output logic [1:0]    p_code,
    output logic [31:0]   clk_hz
);
    srch_state_e     st;
    logic [DW-1:0]   ref_q;
    logic [DW-1:0]   tgt_q;
    logic [DW-1:0]   win_lo;
    logic [DW-1:0]   win_hi;
    logic [DW-1:0]   ref33;
    logic [DW-1:0]   ref_r;
    logic [DW-1:0]   f_cur;
    logic [DW-1:0]   ph_score;
    logic            ph_ok;
    logic [RW-1:0]   r_cur;
    logic [IDXW-1:0] od_idx;
    logic [ODW-1:0]  od_cur;
    logic [DW-1:0]   vco_hold;
    logic [DW-1:0]   clk_hold;

    logic            div_go;
    logic            div_done;
    logic [DW-1:0]   div_num;
    logic [DW-1:0]   div_den;
    logic [DW-1:0]   div_quo;

    logic [DW-1:0]   ev_vco;
    logic [DW-1:0]   ev_clk;
    logic            ev_ok;
    logic            ev_beyond;
    logic            f_legal;

    cand_t           cand;
    cand_t           best;
    logic            best_found;
    logic            offer;
    logic            clear_best;

    logic            res_found;
    logic [RW-1:0]   res_r;
    logic [FW-1:0]   res_f;
    logic [ODW-1:0]  res_p;
    logic [DW-1:0]   res_clk;

    always_comb begin
        od_cur  = od_of_idx(od_idx);
        f_legal = (f_cur >= F_LO) && (f_cur <= F_HI);
    end

    // operand selection for the shared divider
    always_comb begin
        div_num = '0;
        div_den = '0;
        case (st)
            ST_D33: begin
                div_num = ref_q;
                div_den = DW'(R_HI);
            end
            ST_DREF: begin
                div_num = ref_q;
                div_den = DW'(r_cur);
            end
            ST_DEST: begin
                div_num = DW'(DW'(r_cur) * ((tgt_q >> EST_SH) << od_cur));
                div_den = ref_q >> EST_SH;
            end
            ST_DPHS: begin
                div_num = ref_r - ref33;
                div_den = (ref_q - ref33) >> SCORE_SH;
            end
            ST_DVCO: begin
                div_num = vco_hold - VCO_LO;
                div_den = DW'(VCO_DEN);
            end
            default: begin
                div_num = '0;
                div_den = '0;
            end
        endcase
    end

    pllsrch_div #(.W(DW)) u_div (
        .clk  (clk),
        .rst  (rst),
        .go   (div_go),
        .num  (div_num),
        .den  (div_den),
        .done (div_done),
        .quo  (div_quo)
    );

    pllsrch_eval u_eval (
        .f         (f_cur[FW-1:0]),
        .ref_per_r (ref_r),
        .od        (od_cur),
        .win_lo    (win_lo),
        .win_hi    (win_hi),
        .vco       (ev_vco),
        .out_clk   (ev_clk),
        .ok        (ev_ok),
        .beyond    (ev_beyond)
    );

    always_comb begin
        offer      = (st == ST_DVCO) && div_done;
        clear_best = (st == ST_IDLE) && start;
        cand.r      = r_cur;
        cand.f      = f_cur[FW-1:0];
        cand.od     = od_cur;
        cand.clk_hz = clk_hold;
        cand.score  = ph_score + div_quo;
    end

    pllsrch_best u_best (
        .clk   (clk),
        .rst   (rst),
        .clear (clear_best),
        .offer (offer),
        .cand  (cand),
        .best  (best),
        .found (best_found)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            ref_q    <= '0;
            tgt_q    <= '0;
            win_lo   <= '0;
            win_hi   <= '0;
            ref33    <= '0;
            ref_r    <= '0;
            f_cur    <= '0;
            ph_score <= '0;
            ph_ok    <= 1'b0;
            r_cur    <= RW'(R_LO);
            od_idx   <= '0;
            vco_hold <= '0;
            clk_hold <= '0;
            div_go   <= 1'b0;
            res_found <= 1'b0;
            res_r    <= '0;
            res_f    <= '0;
            res_p    <= '0;
            res_clk  <= '0;
        end else begin
            div_go <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        ref_q  <= ref_hz;
                        tgt_q  <= target_hz;
                        win_lo <= target_hz - (target_hz >> WIN_SH);
                        win_hi <= target_hz + (target_hz >> WIN_SH);
                        st     <= ST_D33;
                        div_go <= 1'b1;
                    end
                end
                ST_D33: begin
                    if (div_done) begin
                        ref33  <= div_quo;
                        od_idx <= '0;
                        r_cur  <= RW'(R_LO);
                        st     <= ST_DREF;
                        div_go <= 1'b1;
                    end
                end
                ST_DREF: begin
                    if (div_done) begin
                        ref_r  <= div_quo;
                        ph_ok  <= 1'b0;
                        st     <= ST_DEST;
                        div_go <= 1'b1;
                    end
                end
                ST_DEST: begin
                    if (div_done) begin
                        f_cur <= (div_quo > F_LO) ? div_quo - DW'(1) : div_quo;
                        st    <= ST_FCHK;
                    end
                end
                ST_FCHK: begin
                    if (!f_legal) begin
                        st <= ST_NEXTR;
                    end else if (ev_ok) begin
                        vco_hold <= ev_vco;
                        clk_hold <= ev_clk;
                        st       <= ph_ok ? ST_DVCO : ST_DPHS;
                        div_go   <= 1'b1;
                    end else if (ev_beyond) begin
                        // output only grows with F: nothing later can fit
                        st <= ST_NEXTR;
                    end else begin
                        f_cur <= f_cur + DW'(1);
                    end
                end
                ST_DPHS: begin
                    if (div_done) begin
                        ph_score <= div_quo;
                        ph_ok    <= 1'b1;
                        st       <= ST_DVCO;
                        div_go   <= 1'b1;
                    end
                end
                ST_DVCO: begin
                    if (div_done) begin
                        f_cur <= f_cur + DW'(1);
                        st    <= ST_FCHK;
                    end
                end
                ST_NEXTR: begin
                    if (r_cur == RW'(R_HI)) begin
                        if (od_idx == IDXW'(OD_STEPS - 1)) begin
                            res_found <= best_found;
                            res_r     <= best_found ? best.r : '0;
                            res_f     <= best_found ? best.f : '0;
                            res_p     <= best_found ? p_of_od(best.od) : '0;
                            res_clk   <= best_found ? best.clk_hz : '0;
                            st        <= ST_DONE;
                        end else begin
                            od_idx <= od_idx + IDXW'(1);
                            r_cur  <= RW'(R_LO);
                            st     <= ST_DREF;
                            div_go <= 1'b1;
                        end
                    end else begin
                        r_cur  <= r_cur + RW'(1);
                        st     <= ST_DREF;
                        div_go <= 1'b1;
                    end
                end
                ST_DONE: begin
                    st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy   = (st != ST_IDLE) && (st != ST_DONE);
        done   = (st == ST_DONE);
        found  = res_found;
        r_val  = res_r;
        f_val  = res_f;
        p_code = res_p;
        clk_hz = res_clk;
    end

    p_busy_follows_start_r1: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !done) |=> busy);

    p_done_single_r1: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_hold_result_r1: assert property (@(posedge clk) disable iff (rst)
        (!$stable(clk_hz) || !$stable(r_val) || !$stable(f_val) || !$stable(found)) |-> done);

    p_r_in_range_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (r_cur >= RW'(R_LO)) && (r_cur <= RW'(R_HI)));

    p_offer_f_range_r10: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DVCO) |-> f_legal);

    p_code_no_two_r7: assert property (@(posedge clk) disable iff (rst)
        (done && found) |-> (p_code != 2'd2));

    p_empty_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |-> (clk_hz == '0 && r_val == '0 && f_val == '0 && p_code == '0));

    p_start_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(ref_q) && $stable(tgt_q)));

endmodule

// File: tb/test_pll_coef_search.sv
module test_pll_coef_search;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 195000;
    localparam int MAX_WAIT   = 40000;
    localparam int NVEC       = 4;
    // {reference Hz, target Hz}
    localparam logic [63:0] VECS [NVEC] = '{
        {32'd14318000, 32'd100000000},
        {32'd14318000, 32'd125000000},
        {32'd16000000, 32'd250000000},
        {32'd12000000, 32'd74250000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [31:0] ref_hz;
    logic [31:0] target_hz;
    logic        busy;
    logic        done;
    logic        found;
    logic [5:0]  r_val;
    logic [9:0]  f_val;
    logic [1:0]  p_code;
    logic [31:0] clk_hz;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_coef_search i_pll_coef_search (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .ref_hz    (ref_hz),
        .target_hz (target_hz),
        .busy      (busy),
        .done      (done),
        .found     (found),
        .r_val     (r_val),
        .f_val     (f_val),
        .p_code    (p_code),
        .clk_hz    (clk_hz)
    );

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // exhaustive software model of the search rules
    function automatic void model(input logic [31:0] rf, input logic [31:0] tg,
                                  output logic fnd, output logic [5:0] ro,
                                  output logic [9:0] fo, output logic [1:0] po,
                                  output logic [31:0] co);
        logic [31:0] lo, hi, sc, est, f, vco, t, ph, vs, s;
        logic [31:0] bs, br, bf, bod, bc;
        logic [31:0] od;
        bs = 0; br = 0; bf = 0; bod = 0; bc = 0;
        lo = tg - (tg >> 8);
        hi = tg + (tg >> 8);
        sc = tg >> 8;
        for (int oi = 0; oi < 3; oi++) begin
            od = (oi == 0) ? 32'd1 : (oi == 1) ? 32'd2 : 32'd0;
            for (int r = 2; r <= 33; r++) begin
                logic [31:0] rr;
                rr = 32'(r);
                est = rr * (sc << od);
                f = est / (rf >> 8);
                if (f > 2) f = f - 1;
                while (f >= 2 && f <= 513) begin
                    vco = f * (rf / rr);
                    if (vco >= 32'd100000000 && vco <= 32'd500000000) begin
                        t = vco >> od;
                        if (t >= lo && t <= hi) begin
                            ph = ((rf / rr) - (rf / 32'd33)) / ((rf - (rf / 32'd33)) >> 10);
                            vs = (vco - 32'd100000000) / 32'd390625;
                            s = ph + vs;
                            if (bs == 0 || (s >= bs && od != 0)) begin
                                bs = s; br = rr; bf = f; bod = od; bc = t;
                            end
                        end
                    end
                    f = f + 1;
                end
            end
        end
        fnd = (bs != 0);
        ro  = fnd ? br[5:0] : 6'd0;
        fo  = fnd ? bf[9:0] : 10'd0;
        po  = !fnd ? 2'd0 : (bod >= 2) ? 2'd3 : bod[1:0];
        co  = fnd ? bc : 32'd0;
    endfunction

    task automatic launch(input logic [31:0] rf, input logic [31:0] tg);
        @(negedge clk);
        ref_hz    = rf;
        target_hz = tg;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R1 busy after start", 32'(busy), 32'd1);
    endtask

    task automatic await_done();
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < MAX_WAIT; i++) begin
            if (done) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
        chk(seen, "R1 done reached", 32'(seen), 32'd1);
        chk(busy == 1'b0, "R1 busy low at done", 32'(busy), 32'd0);
    endtask

    task automatic compare(input logic [31:0] rf, input logic [31:0] tg);
        logic efnd;
        logic [5:0] er;
        logic [9:0] ef;
        logic [1:0] ep;
        logic [31:0] ec, vco, od;
        model(rf, tg, efnd, er, ef, ep, ec);
        chk(found == efnd, "R6 found", 32'(found), 32'(efnd));
        chk(r_val == er, "R2 r_val", 32'(r_val), 32'(er));
        chk(f_val == ef, "R5 f_val", 32'(f_val), 32'(ef));
        chk(p_code == ep, "R7 p_code", 32'(p_code), 32'(ep));
        chk(clk_hz == ec, "R6 clk_hz", clk_hz, ec);
        if (found) begin
            chk(clk_hz >= tg - (tg >> 8) && clk_hz <= tg + (tg >> 8), "R3 window", clk_hz, tg);
            chk(r_val >= 6'd2 && r_val <= 6'd33, "R10 r range", 32'(r_val), 32'd2);
            chk(f_val >= 10'd2 && f_val <= 10'd513, "R10 f range", 32'(f_val), 32'd2);
            od  = (p_code == 2'd3) ? 32'd2 : 32'(p_code);
            vco = 32'(f_val) * (rf / 32'(r_val));
            chk(vco >= 32'd100000000 && vco <= 32'd500000000, "R4 vco band", vco, 32'd100000000);
            chk((vco >> od) == clk_hz, "R4 clock from vco", vco >> od, clk_hz);
        end
        @(negedge clk);
        chk(done == 1'b0, "R1 done one cycle", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        start = 1'b0;
        ref_hz = '0;
        target_hz = '0;
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1 reset idle", 32'({busy, done}), 32'd0);
        chk(found == 1'b0 && clk_hz == '0, "R8 reset outputs", clk_hz, 32'd0);
        rst = 1'b0;

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            launch(VECS[v][63:32], VECS[v][31:0]);
            await_done();
            compare(VECS[v][63:32], VECS[v][31:0]);
        end

        // OD 1 gives a VCO below the band, so only OD 2 remains (R7 code 3)
        launch(32'd10000000, 32'd48000000);
        await_done();
        chk(found && p_code == 2'd3, "R7 shift two reports 3", 32'(p_code), 32'd3);
        compare(32'd10000000, 32'd48000000);

        // only OD 0 fits; later OD 0 ties never replace (R6, R7 code 0)
        launch(32'd14318000, 32'd400000000);
        await_done();
        chk(found && p_code == 2'd0, "R7 shift zero reports 0", 32'(p_code), 32'd0);
        compare(32'd14318000, 32'd400000000);

        // no setting below or above the VCO band
        launch(32'd14318000, 32'd1000000);
        await_done();
        chk(!found && clk_hz == 0 && r_val == 0 && f_val == 0, "R8 nothing low", clk_hz, 32'd0);
        compare(32'd14318000, 32'd1000000);

        launch(32'd8000000, 32'd600000000);
        await_done();
        chk(!found && clk_hz == 0 && p_code == 0, "R8 nothing high", clk_hz, 32'd0);
        compare(32'd8000000, 32'd600000000);

        // second start while busy is ignored (R9)
        launch(32'd14318000, 32'd100000000);
        repeat (200) @(negedge clk);
        ref_hz    = 32'd16000000;
        target_hz = 32'd250000000;
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9 still busy", 32'(busy), 32'd1);
        await_done();
        compare(32'd14318000, 32'd100000000);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule